// File: doc/BRIEF.md
# Next Sub-Bank Precharge Predictor

This block steers bitline precharge for an instruction cache whose data array is divided into sub-banks. Only one sub-bank has its bitlines precharged in any cycle; the rest stay unprecharged so that their bitline leakage is cut. A direct-mapped prediction table, indexed by a hash of the fetch's set index and sub-bank index, records which sub-bank the fetch stream entered after it last left that location. After each completed fetch, the block moves precharge to the predicted sub-bank so that the next access finds its bitlines ready.

When a fetch lands on a sub-bank that is not precharged, the block raises a one-cycle stall and switches precharge to the accessed sub-bank. The requester holds the fetch during the stall, and the access completes in the following cycle. The table learns from the fetch stream itself: whenever two completed fetches in a row sit in different sub-banks, the entry for the earlier one is written with the later sub-bank. A separate update port lets a resolved branch write an entry directly. Sequential runs that cross a sub-bank edge and unconditional jumps are learned in the same way. Fetches that stay inside one sub-bank, such as most conditional branch targets, keep precharge where it is.

Top module: `nsb_precharge_pred`

## Requirements
- R1: After reset, sub-bank 0 is the only precharged sub-bank, `fetch_stall` is low and every table entry is invalid.
- R2: `precharge_en` has exactly one bit set in every cycle after reset. Bit b set means sub-bank b is precharged.
- R3: A valid fetch to a sub-bank whose `precharge_en` bit is low raises `fetch_stall` in that cycle. In the next cycle only that sub-bank's bit is set.
- R4: A valid fetch to the precharged sub-bank is not stalled. `fetch_stall` is never high without a valid fetch.
- R5: A completed fetch whose table entry is invalid predicts its own sub-bank, so precharge stays on that sub-bank in the next cycle.
- R6: When a completed fetch lies in sub-bank B and the previous completed fetch was at set S in sub-bank A, with A different from B, the entry for (S, A) is written valid with B. A lookup in the same cycle still reads the old contents; the new value is seen from the next cycle on. Consecutive completed fetches in the same sub-bank write nothing.
- R7: `pred_next_sb` shows the valid entry's sub-bank for the presented fetch (or the fetch's own sub-bank if the entry is invalid). After a completed fetch, `precharge_en` selects that prediction in the next cycle.
- R8: The table index is {F, sub-bank}, with the sub-bank in the low bits. F is the set index XOR-folded into the remaining index bits: set bit i goes to bit i mod (index width minus sub-bank width). With the default parameters (128 sets, 4 sub-banks, 64 entries), F = set[3:0] ^ {0, set[6:4]}. Sets that fold to the same F share an entry.
- R9: `upd_valid` writes the entry for (`upd_set`, `upd_from_sb`) valid with `upd_to_sb`. It takes effect from the next cycle. If a learning write from R6 falls in the same cycle, only the update port's write is made.
- R10: In a cycle with no valid fetch, `precharge_en` does not change. A stalled fetch does not count as the previous completed fetch for R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_valid | input | 1 | A fetch is presented this cycle |
| fetch_set | input | SET_W | Cache set index of the fetch |
| fetch_sb | input | SB_W | Sub-bank index of the fetch |
| upd_valid | input | 1 | Write a resolved transition into the table |
| upd_set | input | SET_W | Set index of the transition source |
| upd_from_sb | input | SB_W | Sub-bank of the transition source |
| upd_to_sb | input | SB_W | Sub-bank the transition enters |
| precharge_en | output | NUM_SUBBANKS | One-hot precharge enable, one bit per sub-bank |
| pred_next_sb | output | SB_W | Predicted next sub-bank for the presented fetch |
| fetch_stall | output | 1 | Fetch hit an unprecharged sub-bank; hold it one cycle |

## Verification
The predictor is driven with a cold sequential run that crosses a sub-bank edge, and then with the same loop replayed. The first pass stalls at every crossing and the replay stalls at none, which separates learning from plain on-demand precharge. A jump within one sub-bank shows that such branches neither stall nor train. Two folded sets that share an entry check the index hash. An update-port write and its collision with a learning write check the write priority. Idle cycles interleaved with updates, and a repeated pseudo-random trace of loops and jumps, are compared cycle by cycle against a reference model of the table and precharge state.

// File: rtl/nsbp_pkg.sv
package nsbp_pkg;
   // legal range of prediction table depth
   localparam int unsigned MIN_TABLE_DEPTH = 64;
   localparam int unsigned MAX_TABLE_DEPTH = 1024;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/nsbp_index.sv
// Maps (set, sub-bank) onto a table index; the sub-bank always takes the low bits.
module nsbp_index #(
   parameter int unsigned SET_W = 7,
   parameter int unsigned SB_W  = 2,
   parameter int unsigned IDX_W = 6
) (
   input  logic [SET_W-1:0] set_i,
   input  logic [SB_W-1:0]  sb_i,
   output logic [IDX_W-1:0] idx_o
);
   localparam int unsigned HI_W  = IDX_W - SB_W;
   localparam int unsigned CAT_W = SET_W + SB_W;

   generate
      if (CAT_W <= IDX_W) begin : g_wide
         // table wide enough: zero-extend the concatenation
         assign idx_o = IDX_W'({set_i, sb_i});
      end else begin : g_fold
         logic [HI_W-1:0] folded;
         always_comb begin
            folded = '0;
            for (int i = 0; i < int'(SET_W); i++) begin
               folded[i % int'(HI_W)] = folded[i % int'(HI_W)] ^ set_i[i];
            end
         end
         assign idx_o = {folded, sb_i};
      end
   endgenerate
endmodule

// File: rtl/nsbp_table.sv
// Direct-mapped next-sub-bank table: valid bits under reset, payload without.
module nsbp_table #(
   parameter int unsigned DEPTH = 64,
   parameter int unsigned SB_W  = 2,
   parameter int unsigned IDX_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output logic             rd_hit,
   output logic [SB_W-1:0]  rd_sb,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [SB_W-1:0]  wr_sb
);
   logic [DEPTH-1:0] ent_vld;
   logic [SB_W-1:0]  ent_sb [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ent_vld <= '0;
      end else if (wr_en) begin
         ent_vld[wr_idx] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         ent_sb[wr_idx] <= wr_sb;
      end
   end

   // read returns contents before any write of this cycle
   assign rd_hit = ent_vld[rd_idx];
   assign rd_sb  = ent_sb[rd_idx];
endmodule

// File: rtl/nsbp_ctrl.sv
// Precharge state, stall decision and transition learning.
module nsbp_ctrl #(
   parameter int unsigned SET_W  = 7,
   parameter int unsigned SB_W   = 2,
   parameter int unsigned NUM_SB = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fetch_valid,
   input  logic [SET_W-1:0]  fetch_set,
   input  logic [SB_W-1:0]   fetch_sb,
   input  logic              look_hit,
   input  logic [SB_W-1:0]   look_sb,
   output logic [NUM_SB-1:0] precharge_en,
   output logic [SB_W-1:0]   pred_sb,
   output logic              stall,
   output logic              learn_en,
   output logic [SET_W-1:0]  learn_set,
   output logic [SB_W-1:0]   learn_from,
   output logic [SB_W-1:0]   learn_to
);
   logic [SB_W-1:0]  live_sb;
   logic             hist_vld;
   logic [SET_W-1:0] hist_set;
   logic [SB_W-1:0]  hist_sb;
   logic             accept;

   assign stall   = fetch_valid && (fetch_sb != live_sb);
   assign accept  = fetch_valid && !stall;
   assign pred_sb = look_hit ? look_sb : fetch_sb;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         live_sb  <= '0;
         hist_vld <= 1'b0;
         hist_set <= '0;
         hist_sb  <= '0;
      end else if (stall) begin
         live_sb <= fetch_sb;
      end else if (accept) begin
         live_sb  <= pred_sb;
         hist_vld <= 1'b1;
         hist_set <= fetch_set;
         hist_sb  <= fetch_sb;
      end
   end

   assign learn_en   = accept && hist_vld && (fetch_sb != hist_sb);
   assign learn_set  = hist_set;
   assign learn_from = hist_sb;
   assign learn_to   = fetch_sb;

   generate
      for (genvar b = 0; b < int'(NUM_SB); b++) begin : g_pre
         assign precharge_en[b] = (live_sb == SB_W'(b));
      end
   endgenerate
endmodule

// File: rtl/nsb_precharge_pred.sv
module nsb_precharge_pred #(
   parameter int unsigned NUM_SETS     = 128,
   parameter int unsigned NUM_SUBBANKS = 4,
   parameter int unsigned TABLE_DEPTH  = 64,
   localparam int unsigned SET_W = $clog2(NUM_SETS),
   localparam int unsigned SB_W  = $clog2(NUM_SUBBANKS),
   localparam int unsigned IDX_W = $clog2(TABLE_DEPTH)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    fetch_valid,
   input  logic [SET_W-1:0]        fetch_set,
   input  logic [SB_W-1:0]         fetch_sb,
   input  logic                    upd_valid,
   input  logic [SET_W-1:0]        upd_set,
   input  logic [SB_W-1:0]         upd_from_sb,
   input  logic [SB_W-1:0]         upd_to_sb,
   output logic [NUM_SUBBANKS-1:0] precharge_en,
   output logic [SB_W-1:0]         pred_next_sb,
   output logic                    fetch_stall
);
   import nsbp_pkg::*;

   generate
      if (!is_pow2(TABLE_DEPTH) || TABLE_DEPTH < MIN_TABLE_DEPTH
          || TABLE_DEPTH > MAX_TABLE_DEPTH) begin : g_bad_depth
         $error("TABLE_DEPTH must be a power of two within the supported range");
      end
      if (!is_pow2(NUM_SUBBANKS) || NUM_SUBBANKS < 2) begin : g_bad_sb
         $error("NUM_SUBBANKS must be a power of two of at least 2");
      end
      if (!is_pow2(NUM_SETS) || NUM_SETS < 2) begin : g_bad_sets
         $error("NUM_SETS must be a power of two of at least 2");
      end
      if (IDX_W <= SB_W) begin : g_bad_idx
         $error("table index must be wider than the sub-bank index");
      end
   endgenerate

   logic [IDX_W-1:0] look_idx, learn_idx, upd_idx, wr_idx;
   logic             look_hit, learn_en, wr_en;
   logic [SB_W-1:0]  look_sb, learn_from, learn_to, wr_sb;
   logic [SET_W-1:0] learn_set;

   nsbp_index #(.SET_W(SET_W), .SB_W(SB_W), .IDX_W(IDX_W)) u_idx_look (
      .set_i(fetch_set), .sb_i(fetch_sb), .idx_o(look_idx));

   nsbp_index #(.SET_W(SET_W), .SB_W(SB_W), .IDX_W(IDX_W)) u_idx_learn (
      .set_i(learn_set), .sb_i(learn_from), .idx_o(learn_idx));

   nsbp_index #(.SET_W(SET_W), .SB_W(SB_W), .IDX_W(IDX_W)) u_idx_upd (
      .set_i(upd_set), .sb_i(upd_from_sb), .idx_o(upd_idx));

   // single write port: resolved update beats learned transition
   assign wr_en  = upd_valid || learn_en;
   assign wr_idx = upd_valid ? upd_idx   : learn_idx;
   assign wr_sb  = upd_valid ? upd_to_sb : learn_to;

   nsbp_table #(.DEPTH(TABLE_DEPTH), .SB_W(SB_W), .IDX_W(IDX_W)) u_table (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_idx (look_idx),
      .rd_hit (look_hit),
      .rd_sb  (look_sb),
      .wr_en  (wr_en),
      .wr_idx (wr_idx),
      .wr_sb  (wr_sb)
   );

   nsbp_ctrl #(.SET_W(SET_W), .SB_W(SB_W), .NUM_SB(NUM_SUBBANKS)) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .fetch_valid  (fetch_valid),
      .fetch_set    (fetch_set),
      .fetch_sb     (fetch_sb),
      .look_hit     (look_hit),
      .look_sb      (look_sb),
      .precharge_en (precharge_en),
      .pred_sb      (pred_next_sb),
      .stall        (fetch_stall),
      .learn_en     (learn_en),
      .learn_set    (learn_set),
      .learn_from   (learn_from),
      .learn_to     (learn_to)
   );
endmodule

// File: rtl/nsbp_checker.sv
module nsbp_checker #(
   parameter int unsigned NUM_SB = 4,
   parameter int unsigned SB_W   = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              fetch_valid,
   input logic [SB_W-1:0]   fetch_sb,
   input logic [NUM_SB-1:0] precharge_en,
   input logic [SB_W-1:0]   pred_next_sb,
   input logic              fetch_stall
);
   assert_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(precharge_en) == 1);

   assert_miss_switch_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_valid && fetch_stall) |=> precharge_en[$past(fetch_sb)]);

   assert_stall_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_stall |-> (fetch_valid && !precharge_en[fetch_sb]));

   assert_follow_pred_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_valid && !fetch_stall) |=> precharge_en[$past(pred_next_sb)]);

   assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !fetch_valid |=> $stable(precharge_en));
endmodule

bind nsb_precharge_pred nsbp_checker #(.NUM_SB(NUM_SUBBANKS), .SB_W(SB_W)) u_nsbp_checker (
   .clk          (clk),
   .rst_n        (rst_n),
   .fetch_valid  (fetch_valid),
   .fetch_sb     (fetch_sb),
   .precharge_en (precharge_en),
   .pred_next_sb (pred_next_sb),
   .fetch_stall  (fetch_stall)
);

// File: tb/nsb_precharge_pred_tb.sv
module nsb_precharge_pred_tb;
   localparam int SET_W = 7;
   localparam int SB_W  = 2;
   localparam int NSB   = 4;
   localparam int DEP   = 64;
   localparam time CLK_P = 20ns;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic fetch_valid = 1'b0;
   logic [SET_W-1:0] fetch_set = '0;
   logic [SB_W-1:0]  fetch_sb = '0;
   logic upd_valid = 1'b0;
   logic [SET_W-1:0] upd_set = '0;
   logic [SB_W-1:0]  upd_from_sb = '0;
   logic [SB_W-1:0]  upd_to_sb = '0;
   logic [NSB-1:0]   precharge_en;
   logic [SB_W-1:0]  pred_next_sb;
   logic             fetch_stall;

   always #(CLK_P/2) clk = ~clk;

   nsb_precharge_pred u_dut (
      .clk(clk), .rst_n(rst_n),
      .fetch_valid(fetch_valid), .fetch_set(fetch_set), .fetch_sb(fetch_sb),
      .upd_valid(upd_valid), .upd_set(upd_set), .upd_from_sb(upd_from_sb),
      .upd_to_sb(upd_to_sb),
      .precharge_en(precharge_en), .pred_next_sb(pred_next_sb),
      .fetch_stall(fetch_stall)
   );

   typedef struct {
      logic [NSB-1:0] pre;
      logic           stall;
      logic           chk_pred;
      logic [SB_W-1:0] pred;
      string          tag;
   } exp_t;

   exp_t exp_q[$];
   event sample_ev;
   int n_checks = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   // reference model state
   bit              m_vld [DEP];
   logic [SB_W-1:0] m_sb  [DEP];
   logic [SB_W-1:0] m_pc;
   bit              m_hv;
   logic [SET_W-1:0] m_hset;
   logic [SB_W-1:0] m_hsb;

   // R8: index = {set[3:0] ^ set[6:4], sb}
   function automatic int idx_of(input logic [SET_W-1:0] s, input logic [SB_W-1:0] b);
      logic [3:0] f;
      f = s[3:0] ^ {1'b0, s[6:4]};
      return int'({f, b});
   endfunction

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int expv);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
      end
   endtask

   // one clock of stimulus; expectations from the model, then model advance
   task automatic step(input bit fv, input logic [SET_W-1:0] s, input logic [SB_W-1:0] b,
                       input bit uv, input logic [SET_W-1:0] us,
                       input logic [SB_W-1:0] uf, input logic [SB_W-1:0] ut,
                       input string tag);
      exp_t e;
      logic [SB_W-1:0] pr;
      bit st, acc, lrn;
      int li;
      @(negedge clk);
      fetch_valid = fv; fetch_set = s; fetch_sb = b;
      upd_valid = uv; upd_set = us; upd_from_sb = uf; upd_to_sb = ut;
      st  = fv && (b != m_pc);
      acc = fv && !st;
      pr  = m_vld[idx_of(s, b)] ? m_sb[idx_of(s, b)] : b;
      e.pre = NSB'(1) << m_pc;
      e.stall = st;
      e.chk_pred = fv;
      e.pred = pr;
      e.tag = tag;
      exp_q.push_back(e);
      #5;
      -> sample_ev;
      lrn = acc && m_hv && (b != m_hsb);
      li  = idx_of(m_hset, m_hsb);
      if (uv) begin
         m_vld[idx_of(us, uf)] = 1'b1;
         m_sb[idx_of(us, uf)]  = ut;
      end else if (lrn) begin
         m_vld[li] = 1'b1;
         m_sb[li]  = b;
      end
      if (st) m_pc = b;
      else if (acc) begin
         m_pc = pr; m_hv = 1'b1; m_hset = s; m_hsb = b;
      end
   endtask

   // fetch held through a stall, as a requester would
   task automatic fetch(input logic [SET_W-1:0] s, input logic [SB_W-1:0] b, input string tag);
      bit miss;
      miss = (b != m_pc);
      step(1'b1, s, b, 1'b0, '0, '0, '0, tag);
      if (miss) step(1'b1, s, b, 1'b0, '0, '0, '0, tag);
   endtask

   task automatic idle(input string tag);
      step(1'b0, '0, '0, 1'b0, '0, '0, '0, tag);
   endtask

   // monitor: compare outputs at the sample point against queued items
   initial begin
      forever begin
         exp_t e;
         @(sample_ev);
         e = exp_q.pop_front();
         check($countones(precharge_en) == 1, "R2", "precharge one-hot count",
               $countones(precharge_en), 1);
         check(precharge_en == e.pre, e.tag, "precharge_en", int'(precharge_en), int'(e.pre));
         check(fetch_stall == e.stall, e.tag, "fetch_stall", int'(fetch_stall), int'(e.stall));
         if (e.chk_pred)
            check(pred_next_sb == e.pred, e.tag, "pred_next_sb", int'(pred_next_sb), int'(e.pred));
      end
   end

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   logic [SET_W-1:0] tr_set [24];
   logic [SB_W-1:0]  tr_sb  [24];

   initial begin
      logic [15:0] lfsr;
      for (int i = 0; i < DEP; i++) begin m_vld[i] = 1'b0; m_sb[i] = '0; end
      m_pc = '0; m_hv = 1'b0; m_hset = '0; m_hsb = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state, invalid entries predict own sub-bank
      idle("R1");
      fetch(7'd0, 2'd0, "R1");
      // R4/R5: sequential run inside sub-bank 0
      for (int s = 1; s < 8; s++) fetch(7'(s), 2'd0, "R5");
      // R3/R6: crossing into sub-bank 1 stalls and trains (7,0)->1
      for (int s = 0; s < 4; s++) fetch(7'(s), 2'd1, "R3");
      // jump back trains (3,1)->0
      fetch(7'd0, 2'd0, "R6");
      // R7: replayed loop: no stalls at the crossings
      for (int rep = 0; rep < 2; rep++) begin
         for (int s = 1; s < 8; s++) fetch(7'(s), 2'd0, "R7");
         for (int s = 0; s < 4; s++) fetch(7'(s), 2'd1, "R7");
         fetch(7'd0, 2'd0, "R7");
      end
      // R6: branch within one sub-bank: no stall, no training
      fetch(7'd10, 2'd0, "R6");
      fetch(7'd2, 2'd0, "R6");
      fetch(7'd2, 2'd0, "R6");
      // R10: idle cycles hold precharge, update port writes meanwhile
      step(1'b0, '0, '0, 1'b1, 7'd5, 2'd2, 2'd3, "R10");
      idle("R10");
      idle("R10");
      // R9: update visible through a later lookup
      fetch(7'd5, 2'd2, "R9");
      fetch(7'd6, 2'd3, "R9");
      // R8: set 22 folds onto set 7 and inherits (7,0)->1
      fetch(7'd22, 2'd0, "R8");
      fetch(7'd1, 2'd1, "R8");
      // R9: update and learning write in the same cycle: update wins
      fetch(7'd40, 2'd1, "R9");
      step(1'b1, 7'd41, 2'd2, 1'b1, 7'd60, 2'd3, 2'd0, "R9");
      step(1'b1, 7'd41, 2'd2, 1'b1, 7'd60, 2'd3, 2'd0, "R9");
      fetch(7'd42, 2'd2, "R9");
      fetch(7'd40, 2'd1, "R9");
      fetch(7'd60, 2'd3, "R9");
      // R6: same-cycle lookup sees the old entry before the write lands
      fetch(7'd60, 2'd3, "R6");
      fetch(7'd61, 2'd2, "R6");
      fetch(7'd60, 2'd3, "R6");
      fetch(7'd61, 2'd2, "R6");

      // R2: repeated pseudo-random trace of runs and jumps with idles
      lfsr = 16'hACE1;
      tr_set[0] = 7'd3; tr_sb[0] = 2'd0;
      for (int k = 1; k < 24; k++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         if (lfsr[2:0] < 3'd5) begin
            tr_set[k] = tr_set[k-1] + 7'd1; tr_sb[k] = tr_sb[k-1];
         end else begin
            tr_set[k] = lfsr[10:4]; tr_sb[k] = lfsr[12:11];
         end
      end
      for (int rep = 0; rep < 12; rep++) begin
         for (int k = 0; k < 24; k++) begin
            fetch(tr_set[k], tr_sb[k], "R2");
            if (((rep + k) % 7) == 0) idle("R10");
         end
      end
      idle("R2");
      @(negedge clk);
      finish_run();
   end
endmodule